// File: doc/BRIEF.md
# NVRAM Multi-Byte Access Sequencer

This block sits between a requester and a byte-wide, byte-addressed non-volatile memory port. It breaks 8-, 16- and 32-bit loads and stores into single-byte accesses, most significant byte at the lowest address. It also moves zero-terminated strings between the memory and a 16-entry internal byte buffer. The requester fills or drains that buffer through an indexed byte port.

A request is offered on `req_valid` together with an opcode, a base address, write data and a length limit. It is taken only in a cycle where `req_ready` is high. No request is queued: a `req_valid` raised while the block is busy is simply not taken, and the requester must present it again later. `busy` stays high for the whole sequence. `done` pulses for one cycle after the final byte access, and the results on `rsp_rdata` and `rsp_count` stay stable until the next request is accepted. On the memory side, a read is issued with `mem_re`, and `mem_rdata` is sampled exactly one cycle later.

Top module: `nvseq_top`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `mem_re` are low, `req_ready` is high, and `rsp_rdata` and `rsp_count` are zero.
- R2: A 16-bit write (op 4) stores `req_wdata[15:8]` at base and `req_wdata[7:0]` at base+1. A 16-bit read (op 1) returns the byte at base in `rsp_rdata[15:8]` and the byte at base+1 in `rsp_rdata[7:0]`, with the upper bits zero.
- R3: A 32-bit write (op 5) or read (op 2) moves bytes at base, base+1, base+2 and base+3, carrying `[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` in that order.
- R4: A byte write (op 3) stores `req_wdata[7:0]` at base only. A byte read (op 0) returns the byte at base in `rsp_rdata[7:0]`, with the upper bits zero.
- R5: Each read byte takes two cycles: `mem_re` is high in one cycle, and `mem_rdata` is taken in the next. `mem_we` and `mem_re` are never high together. Each written byte takes one cycle.
- R6: A string write (op 6) copies buffer entries 0, 1, ... to base, base+1, ... and stops at the first zero entry or at the length limit, whichever comes first. The zero entry itself is not copied. `rsp_count` reports the number of bytes copied.
- R7: Every string write with a nonzero limit ends with one write of zero at base+limit-1, even if the copy stopped earlier.
- R8: A string read (op 7) first clears the whole buffer. It then reads base+i into entry i until it reads a zero byte or reaches the limit. `rsp_count` is the index of the zero byte, or the limit if no zero byte was read. The entries past the stop point stay zero.
- R9: A string operation with a limit of zero makes no memory access and reports a count of zero. A limit above 16 is treated as 16.
- R10: A request is taken only when `req_valid` and `req_ready` are both high, and `req_ready` is low while `busy` is high. A request offered while busy has no effect on the memory or on the buffer.
- R11: `done` is high for exactly one cycle, in the cycle after the last byte access. A write of n bytes shows `done` n cycles after acceptance, and a read of n bytes shows it 2n cycles after acceptance. Memory accesses happen only while `busy` is high.
- R12: While the block is idle, `buf_we` writes `buf_wdata` into entry `buf_idx`. `buf_rdata` always shows entry `buf_idx`. A `buf_we` raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request this cycle |
| req_op | input | 3 | Opcode (0..7, see requirements) |
| req_addr | input | AW | Base byte address |
| req_wdata | input | 32 | Write data for scalar writes |
| req_maxlen | input | LW | Length limit for string operations |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled scalar read data |
| rsp_count | output | LW | Bytes moved, or string stop index |
| buf_we | input | 1 | Buffer write strobe (honoured when idle) |
| buf_idx | input | IW | Buffer entry index |
| buf_wdata | input | 8 | Buffer write byte |
| buf_rdata | output | 8 | Buffer entry at `buf_idx` |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read issue |
| mem_rdata | input | 8 | Memory read byte, one cycle after `mem_re` |

## Verification
The checker assumes that the memory answers every `mem_re` with valid data in the very next cycle. It also assumes that requests follow the valid/ready rule, so a request that is not taken is never counted as accepted. The bench memory model registers its read byte on the clock edge that closes the issue cycle, which gives exactly that latency. The bench drives every request and buffer strobe one half-period away from the active edge, and it withdraws `req_valid` after one cycle. Its only overlapping stimulus, a request and a buffer write raised during a busy sequence, is there to check that both are ignored.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [2:0] {
    OP_RD8  = 3'd0,
    OP_RD16 = 3'd1,
    OP_RD32 = 3'd2,
    OP_WR8  = 3'd3,
    OP_WR16 = 3'd4,
    OP_WR32 = 3'd5,
    OP_SWR  = 3'd6,
    OP_SRD  = 3'd7
  } nv_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_RISSUE,
    ST_RCAPT
  } nv_state_e;

  function automatic logic op_is_write(nv_op_e op);
    return (op == OP_WR8) || (op == OP_WR16) || (op == OP_WR32) || (op == OP_SWR);
  endfunction

  function automatic logic op_is_string(nv_op_e op);
    return (op == OP_SWR) || (op == OP_SRD);
  endfunction

  // Scalar byte count; string ops are sized by their limit instead.
  function automatic logic [2:0] op_scalar_bytes(nv_op_e op);
    case (op)
      OP_RD8,  OP_WR8:  return 3'd1;
      OP_RD16, OP_WR16: return 3'd2;
      OP_RD32, OP_WR32: return 3'd4;
      default:          return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/nvseq_strbuf.sv
module nvseq_strbuf #(
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ext_we,
  input  logic [IW-1:0] ext_idx,
  input  logic [7:0]    ext_wdata,
  output logic [7:0]    ext_rdata,
  input  logic          int_we,
  input  logic [IW-1:0] int_idx,
  input  logic [7:0]    int_wdata,
  output logic [7:0]    int_rdata
);

  logic [DEPTH-1:0][7:0] cell_q;

  // Clear wins over the sequencer, the sequencer wins over the external port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (clr)
          cell_q[e] <= '0;
        else if (int_we && (int_idx == IW'(e)))
          cell_q[e] <= int_wdata;
        else if (ext_we && (ext_idx == IW'(e)))
          cell_q[e] <= ext_wdata;
      end
    end
  end

  assign ext_rdata = cell_q[ext_idx];
  assign int_rdata = cell_q[int_idx];

endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [LW-1:0] req_maxlen,
  output logic          busy,
  output logic          done,
  output logic [31:0]   rsp_rdata,
  output logic [LW-1:0] rsp_count,
  output logic          buf_clr,
  output logic          buf_we,
  output logic [IW-1:0] buf_idx,
  output logic [7:0]    buf_wdata,
  input  logic [7:0]    buf_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata
);

  nv_state_e     state_q;
  nv_op_e        op_q;
  logic [AW-1:0] base_q;
  logic [31:0]   wdata_q;
  logic [LW-1:0] lim_q;
  logic [LW-1:0] idx_q;
  logic [31:0]   rdata_q;
  logic [LW-1:0] count_q;
  logic          done_q;

  nv_op_e        op_in;
  logic [LW-1:0] clamp_len;
  logic [LW-1:0] lim_in;
  logic [LW-1:0] lane;
  logic [31:0]   wshift;
  logic          copy_ok;
  logic          last_byte;
  logic [AW-1:0] term_addr;

  assign op_in     = nv_op_e'(req_op);
  assign clamp_len = (req_maxlen > LW'(DEPTH)) ? LW'(DEPTH) : req_maxlen;
  assign lim_in    = op_is_string(op_in) ? clamp_len : LW'(op_scalar_bytes(op_in));

  // Big-endian lane pick: the first byte sent is the most significant one.
  assign lane      = lim_q - idx_q - LW'(1);
  assign wshift    = wdata_q >> {lane, 3'b000};
  assign copy_ok   = (idx_q < lim_q) && (buf_rdata != 8'h00);
  assign last_byte = (idx_q + LW'(1)) == lim_q;
  assign term_addr = base_q + AW'(lim_q) - AW'(1);

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign rsp_rdata = rdata_q;
  assign rsp_count = count_q;
  assign buf_idx   = idx_q[IW-1:0];
  assign buf_wdata = mem_rdata;
  assign buf_clr   = (state_q == ST_IDLE) && req_valid && (op_in == OP_SRD);

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = base_q + AW'(idx_q);
    mem_wdata = wshift[7:0];
    buf_we    = 1'b0;
    case (state_q)
      ST_WRITE: begin
        mem_we = 1'b1;
        if (op_q == OP_SWR) begin
          if (copy_ok) begin
            mem_wdata = buf_rdata;
          end else begin
            mem_addr  = term_addr;
            mem_wdata = 8'h00;
          end
        end
      end
      ST_RISSUE: mem_re = 1'b1;
      ST_RCAPT:  buf_we = (op_q == OP_SRD);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_RD8;
      base_q  <= '0;
      wdata_q <= '0;
      lim_q   <= '0;
      idx_q   <= '0;
      rdata_q <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= op_in;
            base_q  <= req_addr;
            wdata_q <= req_wdata;
            lim_q   <= lim_in;
            idx_q   <= '0;
            rdata_q <= '0;
            count_q <= '0;
            if (lim_in == '0)
              done_q <= 1'b1;
            else if (op_is_write(op_in))
              state_q <= ST_WRITE;
            else
              state_q <= ST_RISSUE;
          end
        end
        ST_WRITE: begin
          if (op_q == OP_SWR) begin
            if (copy_ok) begin
              idx_q <= idx_q + LW'(1);
            end else begin
              // This cycle carried the terminator write.
              count_q <= idx_q;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else if (last_byte) begin
            count_q <= lim_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + LW'(1);
          end
        end
        ST_RISSUE: state_q <= ST_RCAPT;
        ST_RCAPT: begin
          if (op_q == OP_SRD) begin
            if (mem_rdata == 8'h00) begin
              count_q <= idx_q;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (last_byte) begin
              count_q <= lim_q;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + LW'(1);
              state_q <= ST_RISSUE;
            end
          end else begin
            rdata_q <= {rdata_q[23:0], mem_rdata};
            if (last_byte) begin
              count_q <= lim_q;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + LW'(1);
              state_q <= ST_RISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nvseq_top.sv
module nvseq_top #(
  parameter int AW    = 16,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [LW-1:0] req_maxlen,
  output logic          busy,
  output logic          done,
  output logic [31:0]   rsp_rdata,
  output logic [LW-1:0] rsp_count,
  input  logic          buf_we,
  input  logic [IW-1:0] buf_idx,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata
);

  logic          sb_clr;
  logic          sb_int_we;
  logic [IW-1:0] sb_int_idx;
  logic [7:0]    sb_int_wdata;
  logic [7:0]    sb_int_rdata;
  logic          ext_we_gated;
  logic          busy_w;

  assign busy         = busy_w;
  assign ext_we_gated = buf_we && !busy_w;

  nvseq_ctrl #(.AW(AW), .DEPTH(DEPTH), .IW(IW), .LW(LW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_maxlen (req_maxlen),
    .busy       (busy_w),
    .done       (done),
    .rsp_rdata  (rsp_rdata),
    .rsp_count  (rsp_count),
    .buf_clr    (sb_clr),
    .buf_we     (sb_int_we),
    .buf_idx    (sb_int_idx),
    .buf_wdata  (sb_int_wdata),
    .buf_rdata  (sb_int_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_rdata  (mem_rdata)
  );

  nvseq_strbuf #(.DEPTH(DEPTH), .IW(IW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sb_clr),
    .ext_we    (ext_we_gated),
    .ext_idx   (buf_idx),
    .ext_wdata (buf_wdata),
    .ext_rdata (buf_rdata),
    .int_we    (sb_int_we),
    .int_idx   (sb_int_idx),
    .int_wdata (sb_int_wdata),
    .int_rdata (sb_int_rdata)
  );

endmodule

// File: rtl/nvseq_checker.sv
module nvseq_checker #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          busy,
  input logic          done,
  input logic [LW-1:0] rsp_count,
  input logic          mem_we,
  input logic          mem_re
);

  assert_no_rw_clash_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_capture_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> busy);

  assert_accept_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy || done));

  assert_done_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(req_valid && req_ready)));

  assert_access_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rsp_count <= LW'(DEPTH)));

endmodule

bind nvseq_top nvseq_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .rsp_count (rsp_count),
  .mem_we    (mem_we),
  .mem_re    (mem_re)
);

// File: tb/nvseq_top_bench.sv
`timescale 1ns/1ps
module nvseq_top_bench;

  localparam int AW = 16;
  localparam int IW = 4;
  localparam int LW = 5;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  cyc;
  } vec_t;

  // Ops: 0 rd8, 1 rd16, 2 rd32, 3 wr8, 4 wr16, 5 wr32.
  localparam vec_t VEC [10] = '{
    '{3'd4, 16'h0010, 32'h0000_1234, 32'h0, 8'd2},          // R2 write
    '{3'd1, 16'h0010, 32'h0, 32'h0000_1234, 8'd4},          // R2 read
    '{3'd0, 16'h0010, 32'h0, 32'h0000_0012, 8'd2},          // R4
    '{3'd0, 16'h0011, 32'h0, 32'h0000_0034, 8'd2},          // R4
    '{3'd5, 16'h0020, 32'hDEAD_BEEF, 32'h0, 8'd4},          // R3 write
    '{3'd2, 16'h0020, 32'h0, 32'hDEAD_BEEF, 8'd8},          // R3 read
    '{3'd1, 16'h0022, 32'h0, 32'h0000_BEEF, 8'd4},          // R2
    '{3'd3, 16'h0021, 32'h0000_005A, 32'h0, 8'd1},          // R4 write
    '{3'd2, 16'h0020, 32'h0, 32'hDE5A_BEEF, 8'd8},          // R3
    '{3'd0, 16'h0023, 32'h0, 32'h0000_00EF, 8'd2}           // R4
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [LW-1:0] req_maxlen = '0;
  logic          busy, done;
  logic [31:0]   rsp_rdata;
  logic [LW-1:0] rsp_count;
  logic          buf_we = 1'b0;
  logic [IW-1:0] buf_idx = '0;
  logic [7:0]    buf_wdata = '0;
  logic [7:0]    buf_rdata;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_we, mem_re;
  logic [7:0]    mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [7:0] nvm [256];

  always #2.5 clk = ~clk;

  nvseq_top u_nvseq_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_maxlen(req_maxlen), .busy(busy), .done(done), .rsp_rdata(rsp_rdata),
    .rsp_count(rsp_count), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  // Behavioural memory with one-cycle read latency.
  always @(posedge clk) begin
    if (mem_we) begin
      nvm[mem_addr[7:0]] <= mem_wdata;
      wr_cnt++;
    end
    if (mem_re) begin
      mem_rdata <= nvm[mem_addr[7:0]];
      rd_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [15:0] addr,
                        input logic [31:0] wd, input logic [LW-1:0] ml, output int cyc);
    @(negedge clk);
    req_op = op; req_addr = addr; req_wdata = wd; req_maxlen = ml; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic buf_put(input int idx, input logic [7:0] val);
    @(negedge clk);
    buf_idx = IW'(idx); buf_wdata = val; buf_we = 1'b1;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic buf_get(input int idx, output logic [7:0] val);
    @(negedge clk);
    buf_idx = IW'(idx);
    #1 val = buf_rdata;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    int cyc;
    int w0, r0;
    logic [7:0] b;
    for (int a = 0; a < 256; a++) nvm[a] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 mem strobes", 32'({mem_we, mem_re}), 32'd0);
    chk("R1 rdata", rsp_rdata, 32'd0);
    chk("R1 count", 32'(rsp_count), 32'd0);
    rst_n = 1'b1;

    // Scalar vector walk: R2 R3 R4 data, R5/R11 latency
    for (int v = 0; v < 10; v++) begin
      run_op(VEC[v].op, VEC[v].addr, VEC[v].wd, '0, cyc);
      chk("R11 done cycle", 32'(cyc), 32'(VEC[v].cyc));
      if (VEC[v].op <= 3'd2) chk("R2/R3/R4 read data", rsp_rdata, VEC[v].exp);
    end
    chk("R2 msb at base", 32'(nvm[8'h10]), 32'h12);
    chk("R2 lsb at base+1", 32'(nvm[8'h11]), 32'h34);
    chk("R3 byte0", 32'(nvm[8'h20]), 32'hDE);
    chk("R4 byte write", 32'(nvm[8'h21]), 32'h5A);
    chk("R3 byte2", 32'(nvm[8'h22]), 32'hBE);
    chk("R3 byte3", 32'(nvm[8'h23]), 32'hEF);
    chk("R4 no spill", 32'(nvm[8'h24]), 32'hFF);

    // R6 R7: string write stopped by a zero entry (op 6)
    buf_put(0, 8'h41); buf_put(1, 8'h42); buf_put(2, 8'h43); buf_put(3, 8'h00);
    for (int k = 4; k < 8; k++) buf_put(k, 8'h55);
    w0 = wr_cnt;
    run_op(3'd6, 16'h0040, '0, LW'(8), cyc);
    chk("R6 count", 32'(rsp_count), 32'd3);
    chk("R6 copy0", 32'(nvm[8'h40]), 32'h41);
    chk("R6 copy2", 32'(nvm[8'h42]), 32'h43);
    chk("R6 zero not copied", 32'(nvm[8'h43]), 32'hFF);
    chk("R6 tail untouched", 32'(nvm[8'h46]), 32'hFF);
    chk("R7 terminator", 32'(nvm[8'h47]), 32'h00);
    chk("R7 write count", 32'(wr_cnt - w0), 32'd4);

    // R6 R7: string write stopped by the limit
    buf_put(0, 8'h57); buf_put(1, 8'h58); buf_put(2, 8'h59); buf_put(3, 8'h5A);
    run_op(3'd6, 16'h0050, '0, LW'(4), cyc);
    chk("R6 full count", 32'(rsp_count), 32'd4);
    chk("R6 full copy", 32'(nvm[8'h52]), 32'h59);
    chk("R7 last slot forced zero", 32'(nvm[8'h53]), 32'h00);

    // R8: string read stops at the zero byte (op 7)
    for (int k = 0; k < 16; k++) buf_put(k, 8'h66);
    r0 = rd_cnt;
    run_op(3'd7, 16'h0050, '0, LW'(8), cyc);
    chk("R8 count", 32'(rsp_count), 32'd3);
    chk("R8 reads", 32'(rd_cnt - r0), 32'd4);
    buf_get(0, b); chk("R8 entry0", 32'(b), 32'h57);
    buf_get(2, b); chk("R8 entry2", 32'(b), 32'h59);
    buf_get(3, b); chk("R8 zero entry", 32'(b), 32'h00);
    buf_get(4, b); chk("R8 cleared tail", 32'(b), 32'h00);
    buf_get(15, b); chk("R8 cleared end", 32'(b), 32'h00);

    // R9: zero limit and oversized limit
    w0 = wr_cnt;
    run_op(3'd6, 16'h0060, '0, LW'(0), cyc);
    chk("R9 zero-limit no write", 32'(wr_cnt - w0), 32'd0);
    chk("R9 zero-limit count", 32'(rsp_count), 32'd0);
    chk("R9 zero-limit done", 32'(cyc), 32'd0);
    r0 = rd_cnt;
    run_op(3'd7, 16'h0060, '0, LW'(0), cyc);
    chk("R9 zero-limit no read", 32'(rd_cnt - r0), 32'd0);
    r0 = rd_cnt;
    run_op(3'd7, 16'h0080, '0, LW'(20), cyc);
    chk("R9 clamp count", 32'(rsp_count), 32'd16);
    chk("R9 clamp reads", 32'(rd_cnt - r0), 32'd16);

    // R10 R12: request and buffer write offered while busy are ignored
    w0 = wr_cnt;
    @(negedge clk);
    req_op = 3'd5; req_addr = 16'h0070; req_wdata = 32'h1122_3344; req_valid = 1'b1;
    @(negedge clk);
    chk("R10 ready low while busy", 32'(req_ready), 32'd0);
    req_op = 3'd3; req_addr = 16'h0078; req_wdata = 32'h99;
    buf_idx = 4'd5; buf_wdata = 8'hAB; buf_we = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; buf_we = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    repeat (4) @(negedge clk);
    chk("R10 dropped request", 32'(nvm[8'h78]), 32'hFF);
    chk("R10 write count", 32'(wr_cnt - w0), 32'd4);
    chk("R3 first byte", 32'(nvm[8'h70]), 32'h11);
    chk("R10 idle after", 32'(busy), 32'd0);
    buf_get(5, b); chk("R12 busy buf write ignored", 32'(b), 32'hFF);

    // R12: idle buffer port
    buf_put(9, 8'hC3);
    buf_get(9, b); chk("R12 idle write", 32'(b), 32'hC3);

    report();
    $finish;
  end

endmodule